// File: doc/BRIEF.md
# Sixteen-Bit Shift and Rotate Unit with Carry

This block moves the bits of a 16-bit operand left or right by 0 to 15 places. An operation code picks one of eight behaviours: logical shifts that fill with zeros, arithmetic shifts (the left one fills with zeros, the right one copies the sign bit), rotates that wrap the bits within 16 bits, and rotates that pass through the carry. A rotate through carry treats the carry and the operand as one 17-bit ring. Each result comes with a carry-out, a zero flag and a negative flag.

The datapath is a logarithmic barrel of four stages. Each stage shifts by a power of two and passes the carry along as a seventeenth bit. A single register stage captures the result and the flags on the rising clock edge at which the input strobe is high. The count arrives as a full 16-bit operand, so a count register of an execution unit can drive it directly. Only the low four bits of the count have any effect.

Top module: `shf_barrel16`

## Requirements
- R1: Only `shift_count[3:0]` sets the shift amount. Bits 15 to 4 of the count have no effect on any output.
- R2: A shift amount of zero copies the operand unchanged to `result`, and `carry_out` equals `carry_in`. This holds for every operation code.
- R3: Operation codes 000 (logical left) and 001 (logical right) fill the vacated positions with 0. For a nonzero amount, `carry_out` is the last bit shifted out.
- R4: Operation code 010 (arithmetic left) fills with 0, exactly like code 000. Code 011 (arithmetic right) fills with copies of operand bit 15. For a nonzero amount, `carry_out` is the last bit shifted out.
- R5: Codes 100 (rotate left) and 101 (rotate right) move each bit that leaves one end into the opposite end. For a nonzero amount, `carry_out` is the last bit moved: `result[0]` for rotate left and `result[15]` for rotate right.
- R6: Codes 110 (rotate left through carry) and 111 (rotate right through carry) rotate the 17-bit ring formed by `{carry_in, operand}` by the amount. `carry_out` is the ring's bit 16 after the rotation, and `carry_in` enters the vacated end.
- R7: `zero_flag` is 1 exactly when `result` is zero. `neg_flag` equals `result[15]`.
- R8: Results are due on the first rising edge after a cycle with `in_valid` high. `out_valid` is high for one cycle per strobe. While no strobe arrives, `result`, `carry_out` and both flags keep their values.
- R9: During reset, `out_valid`, `result`, `carry_out`, `zero_flag` and `neg_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: the inputs in this cycle form one operation |
| op_code | input | 3 | Operation select, encoded as in R3 to R6 |
| operand | input | 16 | Data to be shifted or rotated |
| shift_count | input | 16 | Count operand; only bits 3..0 are used |
| carry_in | input | 1 | Stored carry flag |
| out_valid | output | 1 | High for one cycle when a new result is present |
| result | output | 16 | Registered shifted value |
| carry_out | output | 1 | Registered carry |
| zero_flag | output | 1 | Registered flag: result is zero |
| neg_flag | output | 1 | Registered flag: copy of result bit 15 |

## Verification
All four results and `out_valid` are due one rising edge after the strobe, because a single register separates them from the inputs. The driver applies inputs at a falling edge and pushes the expected values into a queue. The monitor samples at each falling edge. When `out_valid` is high it pops one entry, so a back-to-back stream is matched in order without counting cycles by hand. In idle cycles the monitor checks that the outputs still hold the last popped values, and it reports any `out_valid` that arrives with an empty queue.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [2:0] {
    OP_LSL = 3'd0,
    OP_LSR = 3'd1,
    OP_ASL = 3'd2,
    OP_ASR = 3'd3,
    OP_ROL = 3'd4,
    OP_ROR = 3'd5,
    OP_RCL = 3'd6,
    OP_RCR = 3'd7
  } shf_op_e;

  // Even codes move bits towards the MSB.
  function automatic logic op_is_left(shf_op_e op);
    logic [2:0] code;
    code = op;
    return ~code[0];
  endfunction

  // Fill bit at the vacated MSB side for right moves that are not rotates.
  function automatic logic right_fill(shf_op_e op, logic sign);
    return (op == OP_ASR) ? sign : 1'b0;
  endfunction

endpackage

// File: rtl/shf_stage.sv
module shf_stage #(
  parameter int W    = 16,
  parameter int STEP = 1
) (
  input  logic            en,
  input  shf_pkg::shf_op_e op,
  input  logic [W:0]      din,   // {carry, data}
  output logic [W:0]      dout
);
  import shf_pkg::*;

  localparam int IW = $clog2(W + 1);

  always_comb begin
    dout = din;
    if (en) begin
      if (op_is_left(op)) begin
        dout[W] = din[IW'(W - STEP)];
        for (int i = 0; i < W; i++) begin
          if (i >= STEP) begin
            dout[i] = din[IW'(i - STEP)];
          end else begin
            case (op)
              OP_ROL:  dout[i] = din[IW'(i - STEP + W)];
              OP_RCL:  dout[i] = din[IW'(i - STEP + W + 1)];
              default: dout[i] = 1'b0;
            endcase
          end
        end
      end else begin
        dout[W] = din[IW'(STEP - 1)];
        for (int i = 0; i < W; i++) begin
          if (i + STEP < W) begin
            dout[i] = din[IW'(i + STEP)];
          end else begin
            case (op)
              OP_ROR:  dout[i] = din[IW'(i + STEP - W)];
              OP_RCR:  dout[i] = din[IW'((i + STEP) % (W + 1))];
              default: dout[i] = right_fill(op, din[W-1]);
            endcase
          end
        end
      end
    end
  end

endmodule

// File: rtl/shf_flags.sv
module shf_flags #(
  parameter int W = 16
) (
  input  logic [W-1:0] res,
  output logic         is_zero,
  output logic         is_neg
);
  assign is_zero = ~|res;
  assign is_neg  = res[W-1];
endmodule

// File: rtl/shf_barrel16.sv
module shf_barrel16 #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op_code,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] shift_count,
  input  logic              carry_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              carry_out,
  output logic              zero_flag,
  output logic              neg_flag
);
  import shf_pkg::*;

  localparam int CNT_BITS = $clog2(DATA_W);

  shf_op_e               op_e;
  logic [CNT_BITS-1:0]   amt;
  logic                  amt_zero;
  logic [DATA_W:0]       chain [0:CNT_BITS];
  logic [DATA_W-1:0]     core_res;
  logic                  core_cout;
  logic                  core_zero;
  logic                  core_neg;

  assign op_e     = shf_op_e'(op_code);
  assign amt      = shift_count[CNT_BITS-1:0];
  assign amt_zero = (amt == '0);
  assign chain[0] = {carry_in, operand};

  for (genvar k = 0; k < CNT_BITS; k++) begin : g_stage
    shf_stage #(.W(DATA_W), .STEP(1 << k)) u_stage (
      .en  (amt[k]),
      .op  (op_e),
      .din (chain[k]),
      .dout(chain[k+1])
    );
  end

  assign core_res  = chain[CNT_BITS][DATA_W-1:0];
  assign core_cout = chain[CNT_BITS][DATA_W];

  shf_flags #(.W(DATA_W)) u_flags (
    .res    (core_res),
    .is_zero(core_zero),
    .is_neg (core_neg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      carry_out <= 1'b0;
      zero_flag <= 1'b0;
      neg_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= core_res;
        carry_out <= core_cout;
        zero_flag <= core_zero;
        neg_flag  <= core_neg;
      end
    end
  end

endmodule

// File: rtl/shf_barrel16_chk.sv
module shf_barrel16_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        op_code,
  input logic [DATA_W-1:0] operand,
  input logic [DATA_W-1:0] shift_count,
  input logic              carry_in,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              carry_out,
  input logic              zero_flag,
  input logic              neg_flag,
  input logic              amt_zero
);
  localparam int CB = $clog2(DATA_W);

  AST_STROBE_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(carry_out))); // R8
  AST_ZERO_AMOUNT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && amt_zero) |=> (result == $past(operand) && carry_out == $past(carry_in))); // R2
  AST_HIGH_COUNT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (|shift_count[DATA_W-1:CB]) && shift_count[CB-1:0] == '0) |=> (result == $past(operand))); // R1
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (zero_flag == (result == '0))); // R7
  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (neg_flag == result[DATA_W-1])); // R7
  AST_LEFT_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !amt_zero && (op_code == 3'd0 || op_code == 3'd2)) |=> !result[0]); // R3
  AST_ASR_KEEPS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code == 3'd3) |=> (result[DATA_W-1] == $past(operand[DATA_W-1]))); // R4
  AST_ROL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !amt_zero && op_code == 3'd4) |=> (carry_out == result[0])); // R5
  AST_ROR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !amt_zero && op_code == 3'd5) |=> (carry_out == result[DATA_W-1])); // R5
  AST_RCL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code == 3'd6 && shift_count[CB-1:0] == CB'(1))
      |=> (result[0] == $past(carry_in) && carry_out == $past(operand[DATA_W-1]))); // R6

endmodule

bind shf_barrel16 shf_barrel16_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
  .operand(operand), .shift_count(shift_count), .carry_in(carry_in),
  .out_valid(out_valid), .result(result), .carry_out(carry_out),
  .zero_flag(zero_flag), .neg_flag(neg_flag), .amt_zero(amt_zero)
);

// File: tb/shf_barrel16_tb.sv
module shf_barrel16_tb;

  typedef struct {
    logic [15:0] res;
    logic        cout;
    logic        z;
    logic        n;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [15:0] operand = '0;
  logic [15:0] shift_count = '0;
  logic        carry_in = 1'b0;
  logic        out_valid;
  logic [15:0] result;
  logic        carry_out, zero_flag, neg_flag;

  int checks = 0;
  int failures = 0;
  exp_t sb[$];
  logic [15:0] last_res = '0;
  logic        last_c = 1'b0;
  logic        mon_on = 1'b0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  shf_barrel16 u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .operand(operand), .shift_count(shift_count), .carry_in(carry_in),
    .out_valid(out_valid), .result(result), .carry_out(carry_out),
    .zero_flag(zero_flag), .neg_flag(neg_flag)
  );

  // One step at a time, repeated count[3:0] times; returns {carry, value}.
  function automatic logic [16:0] ref_model(logic [2:0] op, logic [15:0] a, logic [15:0] cnt, logic c);
    logic t;
    for (int s = 0; s < int'(cnt[3:0]); s++) begin
      case (op)
        3'd0, 3'd2: begin c = a[15]; a = {a[14:0], 1'b0}; end
        3'd1:       begin c = a[0];  a = {1'b0, a[15:1]}; end
        3'd3:       begin c = a[0];  a = {a[15], a[15:1]}; end
        3'd4:       begin c = a[15]; a = {a[14:0], a[15]}; end
        3'd5:       begin c = a[0];  a = {a[0], a[15:1]}; end
        3'd6:       begin t = a[15]; a = {a[14:0], c}; c = t; end
        default:    begin t = a[0];  a = {c, a[15:1]}; c = t; end
      endcase
    end
    return {c, a};
  endfunction

  function automatic string op_tag(logic [2:0] op, logic [15:0] cnt);
    if (cnt[15:4] != 0 || cnt[3:0] == 0) return (cnt[3:0] == 0) ? "R2/R1" : "R1";
    case (op)
      3'd0, 3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      default:    return "R6";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Applies one strobed operation for one cycle and queues what it must produce.
  task automatic apply(logic [2:0] op, logic [15:0] a, logic [15:0] cnt, logic c);
    exp_t e;
    logic [16:0] m;
    m = ref_model(op, a, cnt, c);
    e.res = m[15:0];
    e.cout = m[16];
    e.z = (m[15:0] == 16'h0);
    e.n = m[15];
    e.tag = op_tag(op, cnt);
    sb.push_back(e);
    op_code = op; operand = a; shift_count = cnt; carry_in = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic apply_lit(logic [2:0] op, logic [15:0] a, logic [15:0] cnt, logic c,
                           logic [15:0] r, logic co, string req);
    logic [16:0] m;
    m = ref_model(op, a, cnt, c);
    check(req, "literal model value", {15'd0, m}, {15'd0, co, r});
    apply(op, a, cnt, c);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: scoreboard pop on each result, hold check otherwise.
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          checks++; failures++;
          $display("FAIL R8 out_valid with empty queue actual=1 expected=0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.tag, "result", {16'd0, result}, {16'd0, e.res});
          check(e.tag, "carry_out", {31'd0, carry_out}, {31'd0, e.cout});
          check("R7", "zero_flag", {31'd0, zero_flag}, {31'd0, e.z});
          check("R7", "neg_flag", {31'd0, neg_flag}, {31'd0, e.n});
          last_res = e.res;
          last_c = e.cout;
        end
      end else begin
        check("R8", "held result", {16'd0, result}, {16'd0, last_res});
        check("R8", "held carry", {31'd0, carry_out}, {31'd0, last_c});
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R9", "result in reset", {16'd0, result}, 32'd0);
    check("R9", "flags in reset", {29'd0, carry_out, zero_flag, neg_flag}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;

    // Directed corners with hand-computed values
    apply_lit(3'd0, 16'h8001, 16'd1, 1'b0, 16'h0002, 1'b1, "R3");
    apply_lit(3'd1, 16'h8001, 16'd1, 1'b0, 16'h4000, 1'b1, "R3");
    apply_lit(3'd2, 16'h4001, 16'd2, 1'b0, 16'h0004, 1'b1, "R4");
    apply_lit(3'd3, 16'h8001, 16'd1, 1'b0, 16'hC000, 1'b1, "R4");
    apply_lit(3'd3, 16'h8000, 16'd15, 1'b0, 16'hFFFF, 1'b0, "R4");
    apply_lit(3'd4, 16'h8001, 16'd4, 1'b0, 16'h0018, 1'b0, "R5");
    apply_lit(3'd5, 16'h0001, 16'd1, 1'b0, 16'h8000, 1'b1, "R5");
    apply_lit(3'd6, 16'h8000, 16'd1, 1'b0, 16'h0000, 1'b1, "R6");
    apply_lit(3'd7, 16'h0001, 16'd1, 1'b1, 16'h8000, 1'b1, "R6");
    apply_lit(3'd6, 16'h0000, 16'd15, 1'b1, 16'h4000, 1'b0, "R6");
    apply_lit(3'd0, 16'h1234, 16'h0000, 1'b1, 16'h1234, 1'b1, "R2");
    apply_lit(3'd7, 16'hA5A5, 16'hFFF0, 1'b0, 16'hA5A5, 1'b0, "R1");
    apply_lit(3'd1, 16'h00F0, 16'h0104, 1'b0, 16'h000F, 1'b0, "R1");
    apply_lit(3'd1, 16'h0001, 16'd1, 1'b0, 16'h0000, 1'b1, "R7");
    idle(3);

    // Random stream, back-to-back with occasional gaps
    for (int k = 0; k < 400; k++) begin
      logic [2:0]  op;
      logic [15:0] a, cnt;
      logic        c;
      op  = 3'($urandom);
      a   = 16'($urandom);
      cnt = 16'($urandom);
      c   = 1'($urandom);
      if (($urandom % 8) == 0) a = 16'h0000;
      apply(op, a, cnt, c);
      if (($urandom % 4) == 0) idle(1 + int'($urandom % 3));
    end
    idle(4);
    check("R8", "queue drained", sb.size(), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule